// File: doc/BRIEF.md
# Postfix Stack Evaluation Engine

This block evaluates arithmetic written in postfix order on an internal operand stack. Each instruction has an opcode and, for the two memory instructions only, a word address. Instructions arrive over a valid/ready handshake. A PUSH copies one word from a small data memory onto the stack. A POP moves the top word back into memory. ADD, SUB and MUL have no operand fields. They consume the two uppermost stack entries and leave one result in their place.

A side port lets the surrounding logic preload the data memory. A combinational peek port reads any memory word back. The current top of stack, the stack depth and two sticky error flags are visible at all times. Illegal stack use raises an error flag and leaves the stack unchanged. Typical use: preload operands, stream a postfix program such as "push X, push Y, mul, push W, push U, mul, add, pop Z", then read Z through the peek port.

Top module: `rpn_engine`

## Requirements
- R1: After a synchronous active-low reset, depth is 0, top_data is 0, in_ready is 1 and both error flags are 0.
- R2: Opcode encoding is NOP=0, PUSH=1, POP=2, ADD=3, SUB=4, MUL=5. Codes 6 and 7 behave as NOP. An accepted PUSH a with depth below 8 holds in_ready low for exactly the next cycle. After the second clock edge, top_data equals memory word a and depth has risen by one.
- R3: An accepted POP a with depth above 0 holds in_ready low for exactly the next cycle. After the second clock edge, memory word a holds the former top and depth has fallen by one.
- R4: An accepted ADD, SUB or MUL with depth of at least 2 completes in one cycle. The entry below the top is the left operand and the top entry is the right operand. Both are replaced by the single result, so depth falls by one.
- R5: ADD and SUB wrap modulo 2^16. MUL keeps the low 16 bits of the product.
- R6: A PUSH accepted at depth 8 sets err_ovf. It completes in one cycle with no memory access and leaves depth and the stack unchanged.
- R7: A POP at depth 0, or an arithmetic instruction at depth below 2, sets err_unf. It completes in one cycle and leaves the stack and memory unchanged.
- R8: Both error flags stay set until reset, whatever instructions follow.
- R9: in_ready is never low for two consecutive cycles.
- R10: NOP, codes 6 and 7, and any opcode presented while in_valid is low change neither the stack, the memory nor the flags.
- R11: A load-port write updates the addressed memory word at the next clock edge. peek_data shows any word combinationally.
- R12: The program push X, push Y, mul, push W, push U, mul, add, pop Z leaves (X*Y + W*U) mod 2^16 in word Z with depth back at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Engine can accept an instruction |
| in_op | input | 3 | Opcode |
| in_addr | input | AW (4) | Memory word for PUSH/POP |
| ld_en | input | 1 | Memory preload write enable |
| ld_addr | input | AW (4) | Preload address |
| ld_data | input | W (16) | Preload data |
| peek_addr | input | AW (4) | Memory read-back address |
| peek_data | output | W (16) | Memory word at peek_addr |
| top_data | output | W (16) | Top of stack, 0 when empty |
| depth | output | CNT_W (4) | Entries on the stack |
| err_ovf | output | 1 | Sticky overflow error |
| err_unf | output | 1 | Sticky underflow error |

## Verification
Arithmetic, rejected and no-op instructions show their effect on depth, top_data and the flags one clock edge after acceptance. A valid PUSH or POP shows its effect two edges after acceptance, and in_ready is low in between. The bench issues each instruction on a falling edge and samples on the following falling edge. For PUSH and POP it first checks that in_ready is low, then waits one more falling edge before comparing against its model. Memory words written by POP or the load port are read through peek_data on the falling edge after the write, because that path has no register.

// File: rtl/rpn_pkg.sv
// Shared encodings for the postfix stack engine.
package rpn_pkg;
    // Instruction opcodes; unlisted codes act as no-operation.
    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_PUSH = 3'd1,
        OP_POP  = 3'd2,
        OP_ADD  = 3'd3,
        OP_SUB  = 3'd4,
        OP_MUL  = 3'd5
    } op_e;

    // Arithmetic unit function select.
    typedef enum logic [1:0] {
        FN_ADD = 2'd0,
        FN_SUB = 2'd1,
        FN_MUL = 2'd2
    } fn_e;

    // Stack update command for one cycle.
    typedef enum logic [1:0] {
        STK_HOLD = 2'd0,
        STK_PUSH = 2'd1,
        STK_POP  = 2'd2,
        STK_FOLD = 2'd3
    } stk_cmd_e;
endpackage

// File: rtl/rpn_alu.sv
// Combinational arithmetic unit: lhs op rhs, result truncated to W bits.
// Assumes lhs is the entry below the top and rhs is the top entry.
module rpn_alu
    import rpn_pkg::*;
#(
    parameter int W = 16
) (
    input  fn_e          fn,
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    output logic [W-1:0] res
);
    // Select the function; every result wraps to W bits.
    always_comb begin
        case (fn)
            FN_SUB:  res = lhs - rhs;
            FN_MUL:  res = lhs * rhs;
            default: res = lhs + rhs;
        endcase
    end
endmodule

// File: rtl/rpn_stack.sv
// Operand stack: DEPTH entries of W bits with an occupancy counter.
// PUSH writes above the top; POP drops the top; FOLD drops the top and
// overwrites the new top with wdata. Assumes the controller never
// pushes when full or pops/folds without enough entries, and that
// DEPTH is a power of two.
module rpn_stack
    import rpn_pkg::*;
#(
    parameter  int W     = 16,
    parameter  int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  stk_cmd_e         cmd,
    input  logic [W-1:0]     wdata,
    output logic [W-1:0]     top,
    output logic [W-1:0]     below,
    output logic [CNT_W-1:0] count
);
    logic [W-1:0]     slot [DEPTH];
    logic [CNT_W-1:0] cnt_m1;
    logic [CNT_W-1:0] cnt_m2;
    logic [PTR_W-1:0] top_idx;
    logic [PTR_W-1:0] below_idx;
    logic [PTR_W-1:0] wr_idx;
    logic             wr_en;

    // Derive entry indices from the counter.
    always_comb begin
        cnt_m1    = count - CNT_W'(1);
        cnt_m2    = count - CNT_W'(2);
        top_idx   = cnt_m1[PTR_W-1:0];
        below_idx = cnt_m2[PTR_W-1:0];
    end

    // Choose which entry is written this cycle.
    always_comb begin
        wr_en  = (cmd == STK_PUSH) || (cmd == STK_FOLD);
        wr_idx = (cmd == STK_PUSH) ? count[PTR_W-1:0] : below_idx;
    end

    // One register per entry, each with its own write strobe.
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        // Capture wdata when this entry is the write target.
        always_ff @(posedge clk) begin
            if (wr_en && (wr_idx == PTR_W'(i))) begin
                slot[i] <= wdata;
            end
        end
    end

    // Track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            case (cmd)
                STK_PUSH: count <= count + CNT_W'(1);
                STK_POP,
                STK_FOLD: count <= count - CNT_W'(1);
                default:  count <= count;
            endcase
        end
    end

    // Present the two upper entries; an empty stack shows zero.
    always_comb begin
        top   = (count != '0) ? slot[top_idx] : '0;
        below = (count > CNT_W'(1)) ? slot[below_idx] : '0;
    end
endmodule

// File: rtl/rpn_dmem.sv
// Data memory of 2**AW words. Two write sources: the engine store path
// (priority) and the preload port. One registered read for PUSH and one
// combinational peek read. Assumes the two writers rarely collide.
module rpn_dmem #(
    parameter  int W      = 16,
    parameter  int AW     = 4,
    localparam int NWORDS = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_en,
    input  logic [AW-1:0] ld_addr,
    input  logic [W-1:0]  ld_data,
    input  logic          st_en,
    input  logic [AW-1:0] st_addr,
    input  logic [W-1:0]  st_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_q,
    input  logic [AW-1:0] peek_addr,
    output logic [W-1:0]  peek_data
);
    logic [W-1:0]  word [NWORDS];
    logic          we;
    logic [AW-1:0] wa;
    logic [W-1:0]  wd;

    // Arbitrate the write port, store path first.
    always_comb begin
        we = st_en || ld_en;
        wa = st_en ? st_addr : ld_addr;
        wd = st_en ? st_data : ld_data;
    end

    for (genvar i = 0; i < NWORDS; i++) begin : g_word
        // Update this word when addressed.
        always_ff @(posedge clk) begin
            if (we && (wa == AW'(i))) begin
                word[i] <= wd;
            end
        end
    end

    // Registered read feeding the PUSH path.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (rd_en) begin
            rd_q <= word[rd_addr];
        end
    end

    // Combinational read-back.
    assign peek_data = word[peek_addr];
endmodule

// File: rtl/rpn_ctrl.sv
// Instruction sequencer. Accepts one instruction when idle. Screens it
// against the stack depth and issues stack, arithmetic and memory
// commands. PUSH and POP spend one extra cycle on the memory. Rejected
// instructions set a sticky flag and finish in one cycle.
module rpn_ctrl
    import rpn_pkg::*;
#(
    parameter  int AW    = 4,
    parameter  int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [2:0]       in_op,
    input  logic [AW-1:0]    in_addr,
    input  logic [CNT_W-1:0] count,
    output logic             in_ready,
    output stk_cmd_e         stk_cmd,
    output fn_e              fn,
    output logic             from_mem,
    output logic             rd_en,
    output logic             st_en,
    output logic [AW-1:0]    st_addr,
    output logic             err_ovf,
    output logic             err_unf
);
    typedef enum logic [1:0] {S_IDLE, S_PUSH_WAIT, S_POP_WAIT} state_e;

    state_e        state, state_nxt;
    logic [AW-1:0] addr_q;
    logic          full, empty, short2;
    logic          set_ovf, set_unf;

    // Depth conditions used for screening.
    always_comb begin
        full   = (count == CNT_W'(DEPTH));
        empty  = (count == '0);
        short2 = (count < CNT_W'(2));
    end

    // Decode and sequence one instruction.
    always_comb begin
        state_nxt = state;
        stk_cmd   = STK_HOLD;
        fn        = FN_ADD;
        from_mem  = 1'b0;
        rd_en     = 1'b0;
        st_en     = 1'b0;
        set_ovf   = 1'b0;
        set_unf   = 1'b0;
        case (state)
            S_IDLE: begin
                if (in_valid) begin
                    case (op_e'(in_op))
                        OP_PUSH: begin
                            if (full) begin
                                set_ovf = 1'b1;
                            end else begin
                                rd_en     = 1'b1;
                                state_nxt = S_PUSH_WAIT;
                            end
                        end
                        OP_POP: begin
                            if (empty) set_unf = 1'b1;
                            else       state_nxt = S_POP_WAIT;
                        end
                        OP_ADD, OP_SUB, OP_MUL: begin
                            if (short2) begin
                                set_unf = 1'b1;
                            end else begin
                                stk_cmd = STK_FOLD;
                                fn = (op_e'(in_op) == OP_SUB) ? FN_SUB :
                                     (op_e'(in_op) == OP_MUL) ? FN_MUL : FN_ADD;
                            end
                        end
                        default: ;
                    endcase
                end
            end
            S_PUSH_WAIT: begin
                stk_cmd   = STK_PUSH;
                from_mem  = 1'b1;
                state_nxt = S_IDLE;
            end
            S_POP_WAIT: begin
                stk_cmd   = STK_POP;
                st_en     = 1'b1;
                state_nxt = S_IDLE;
            end
            default: state_nxt = S_IDLE;
        endcase
    end

    assign in_ready = (state == S_IDLE);
    assign st_addr  = addr_q;

    // State, latched address and sticky error flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            addr_q  <= '0;
            err_ovf <= 1'b0;
            err_unf <= 1'b0;
        end else begin
            state <= state_nxt;
            if (in_valid && in_ready) addr_q <= in_addr;
            if (set_ovf) err_ovf <= 1'b1;
            if (set_unf) err_unf <= 1'b1;
        end
    end
endmodule

// File: rtl/rpn_engine.sv
// Top of the postfix stack engine. Joins sequencer, stack, arithmetic
// unit and data memory. The stack write data comes from memory during a
// PUSH and from the arithmetic unit otherwise.
module rpn_engine
    import rpn_pkg::*;
#(
    parameter  int W     = 16,
    parameter  int AW    = 4,
    parameter  int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [2:0]       in_op,
    input  logic [AW-1:0]    in_addr,
    input  logic             ld_en,
    input  logic [AW-1:0]    ld_addr,
    input  logic [W-1:0]     ld_data,
    input  logic [AW-1:0]    peek_addr,
    output logic [W-1:0]     peek_data,
    output logic [W-1:0]     top_data,
    output logic [CNT_W-1:0] depth,
    output logic             err_ovf,
    output logic             err_unf
);
    stk_cmd_e      stk_cmd;
    fn_e           fn;
    logic          from_mem, rd_en, st_en;
    logic [AW-1:0] st_addr;
    logic [W-1:0]  below, alu_res, rd_q, stk_wdata;

    rpn_ctrl #(.AW(AW), .DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_addr(in_addr), .count(depth), .in_ready(in_ready),
        .stk_cmd(stk_cmd), .fn(fn), .from_mem(from_mem), .rd_en(rd_en),
        .st_en(st_en), .st_addr(st_addr), .err_ovf(err_ovf), .err_unf(err_unf)
    );

    rpn_alu #(.W(W)) u_alu (
        .fn(fn), .lhs(below), .rhs(top_data), .res(alu_res)
    );

    // Pick the stack write source.
    assign stk_wdata = from_mem ? rd_q : alu_res;

    rpn_stack #(.W(W), .DEPTH(DEPTH)) u_stack (
        .clk(clk), .rst_n(rst_n), .cmd(stk_cmd), .wdata(stk_wdata),
        .top(top_data), .below(below), .count(depth)
    );

    rpn_dmem #(.W(W), .AW(AW)) u_mem (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_addr(ld_addr),
        .ld_data(ld_data), .st_en(st_en), .st_addr(st_addr), .st_data(top_data),
        .rd_en(rd_en), .rd_addr(in_addr), .rd_q(rd_q),
        .peek_addr(peek_addr), .peek_data(peek_data)
    );
endmodule

// File: rtl/rpn_engine_chk.sv
// Port-level temporal checks for rpn_engine, attached by bind.
module rpn_engine_chk #(
    parameter  int W     = 16,
    parameter  int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic [2:0]       in_op,
    input logic [W-1:0]     top_data,
    input logic [CNT_W-1:0] depth,
    input logic             err_ovf,
    input logic             err_unf
);
    logic acc, acc_push, acc_pop, acc_bin;
    assign acc      = in_valid && in_ready;
    assign acc_push = acc && (in_op == 3'd1);
    assign acc_pop  = acc && (in_op == 3'd2);
    assign acc_bin  = acc && (in_op >= 3'd3) && (in_op <= 3'd5);

    // R2
    push_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_push && (depth < CNT_W'(DEPTH)) |=> !in_ready);
    // R3
    pop_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_pop && (depth != '0) |=> !in_ready);
    // R4
    fold_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_bin && (depth >= CNT_W'(2)) |=> depth == $past(depth) - CNT_W'(1));
    // R6
    full_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_push && (depth == CNT_W'(DEPTH)) |=> err_ovf && in_ready && $stable(depth) && $stable(top_data));
    // R7
    short_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_bin && (depth < CNT_W'(2)) |=> err_unf && $stable(depth) && $stable(top_data));
    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_ovf |=> err_ovf);
    // R8
    unf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_unf |=> err_unf);
    // R9
    single_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |=> in_ready);
    // R6
    depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        depth <= CNT_W'(DEPTH));
endmodule

bind rpn_engine rpn_engine_chk #(.W(W), .DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .top_data(top_data), .depth(depth),
    .err_ovf(err_ovf), .err_unf(err_unf)
);

// File: tb/sim_rpn_engine.sv
`timescale 1ns/1ps
module sim_rpn_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [2:0]  in_op = 3'd0;
    logic [3:0]  in_addr = 4'd0;
    logic        ld_en = 1'b0;
    logic [3:0]  ld_addr = 4'd0;
    logic [15:0] ld_data = 16'd0;
    logic [3:0]  peek_addr = 4'd0;
    logic [15:0] peek_data;
    logic [15:0] top_data;
    logic [3:0]  depth;
    logic        err_ovf, err_unf;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [15:0] mmem [16];
    logic [15:0] mstk [8];
    int          mdepth = 0;
    bit          movf = 0, munf = 0;

    rpn_engine u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .in_addr(in_addr), .ld_en(ld_en), .ld_addr(ld_addr),
        .ld_data(ld_data), .peek_addr(peek_addr), .peek_data(peek_data),
        .top_data(top_data), .depth(depth), .err_ovf(err_ovf), .err_unf(err_unf)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic state_chk(input string req);
        chk({req, " depth"}, 32'(depth), 32'(mdepth));
        chk({req, " top"}, 32'(top_data), (mdepth > 0) ? 32'(mstk[mdepth-1]) : 32'd0);
        chk({req, " ovf"}, 32'(err_ovf), 32'(movf));
        chk({req, " unf"}, 32'(err_unf), 32'(munf));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        mdepth = 0; movf = 0; munf = 0;
    endtask

    // R11: preload one word and read it back
    task automatic load(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        ld_en = 1'b1; ld_addr = a; ld_data = d;
        @(negedge clk);
        ld_en = 1'b0;
        mmem[a] = d;
        peek_addr = a;
        #1 chk("R11 load", 32'(peek_data), 32'(d));
    endtask

    task automatic peek(input string req, input logic [3:0] a, input logic [15:0] exp);
        peek_addr = a;
        #1 chk(req, 32'(peek_data), 32'(exp));
    endtask

    // Issue one instruction, update the model and wait until it is done.
    task automatic issue(input logic [2:0] op, input logic [3:0] a);
        bit        longop;
        logic [15:0] l, r, res;
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1; in_op = op; in_addr = a;
        @(negedge clk);
        in_valid = 1'b0;
        longop = (op == 3'd1 && mdepth < 8) || (op == 3'd2 && mdepth > 0);
        if (longop) begin
            chk("R9 ready low during memory cycle", 32'(in_ready), 32'd0);
            @(negedge clk);
        end
        case (op)
            3'd1: if (mdepth == 8) movf = 1; else begin mstk[mdepth] = mmem[a]; mdepth++; end
            3'd2: if (mdepth == 0) munf = 1; else begin mdepth--; mmem[a] = mstk[mdepth]; end
            3'd3, 3'd4, 3'd5: begin
                if (mdepth < 2) munf = 1;
                else begin
                    l = mstk[mdepth-2]; r = mstk[mdepth-1];
                    if (op == 3'd3) res = 16'((32'(l) + 32'(r)) % 65536);
                    else if (op == 3'd4) res = 16'((32'(l) + 65536 - 32'(r)) % 65536);
                    else res = 16'((32'(l) * 32'(r)) % 65536);
                    mstk[mdepth-2] = res;
                    mdepth--;
                end
            end
            default: ;
        endcase
        chk("R9 ready back high", 32'(in_ready), 32'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] vals [8];
        logic [15:0] exp;
        vals[0] = 16'h0000; vals[1] = 16'h0001; vals[2] = 16'h0002; vals[3] = 16'h7FFF;
        vals[4] = 16'h8000; vals[5] = 16'hFFFF; vals[6] = 16'h1234; vals[7] = 16'h00FF;

        do_reset();
        // R1: reset state
        #1 state_chk("R1 reset");
        chk("R1 ready", 32'(in_ready), 32'd1);

        // R2 R6: fill the stack, then overflow
        for (int k = 0; k < 8; k++) load(4'(k), 16'(k * 16'h1111 + 3));
        for (int k = 0; k < 8; k++) begin
            issue(3'd1, 4'(k));
            state_chk("R2 push");
        end
        issue(3'd1, 4'd0);
        state_chk("R6 push when full");

        // R3: drain to addresses 8..15 and read back
        for (int k = 0; k < 8; k++) begin
            issue(3'd2, 4'(8 + k));
            state_chk("R3 pop");
            peek("R3 popped word", 4'(8 + k), 16'((7 - k) * 16'h1111 + 3));
        end

        // R7: pop at empty leaves memory alone
        issue(3'd2, 4'd8);
        state_chk("R7 pop empty");
        peek("R7 memory untouched", 4'd8, mmem[8]);

        // R8: flags persist across good instructions
        issue(3'd1, 4'd2);
        issue(3'd2, 4'd9);
        state_chk("R8 sticky");

        // R1: reset clears flags
        do_reset();
        #1 state_chk("R1 reset clears");

        // R7: arithmetic with a single entry
        issue(3'd1, 4'd5);
        issue(3'd3, 4'd0);
        state_chk("R7 fold short");
        do_reset();

        // R10: no-op codes and idle handshake
        issue(3'd1, 4'd6);
        issue(3'd0, 4'd7);
        state_chk("R10 nop");
        issue(3'd6, 4'd7);
        state_chk("R10 code 6");
        issue(3'd7, 4'd7);
        state_chk("R10 code 7");
        @(negedge clk);
        in_valid = 1'b0; in_op = 3'd2; in_addr = 4'd10;
        repeat (2) @(negedge clk);
        state_chk("R10 valid low");
        peek("R10 memory unchanged", 4'd10, mmem[10]);
        issue(3'd2, 4'd11);

        // R4 R5: sweep operand pairs and all three functions
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                for (int f = 0; f < 3; f++) begin
                    load(4'd0, vals[i]);
                    load(4'd1, vals[j]);
                    issue(3'd1, 4'd0);
                    issue(3'd1, 4'd1);
                    issue(3'(3 + f), 4'd0);
                    if (f == 0) exp = 16'((32'(vals[i]) + 32'(vals[j])) % 65536);
                    else if (f == 1) exp = 16'((32'(vals[i]) + 65536 - 32'(vals[j])) % 65536);
                    else exp = 16'((32'(vals[i]) * 32'(vals[j])) % 65536);
                    chk("R4 R5 result", 32'(top_data), 32'(exp));
                    chk("R4 depth", 32'(depth), 32'd1);
                    issue(3'd2, 4'd2);
                    peek("R5 stored result", 4'd2, exp);
                end
            end
        end

        // R12: postfix program, small and wrapping operands
        for (int t = 0; t < 2; t++) begin
            logic [15:0] x, y, w, u;
            x = t ? 16'd300 : 16'd3;   y = t ? 16'd300 : 16'd5;
            w = t ? 16'd256 : 16'd7;   u = t ? 16'd256 : 16'd11;
            load(4'd0, x); load(4'd1, y); load(4'd2, w); load(4'd3, u);
            issue(3'd1, 4'd0); issue(3'd1, 4'd1); issue(3'd5, 4'd0);
            issue(3'd1, 4'd2); issue(3'd1, 4'd3); issue(3'd5, 4'd0);
            issue(3'd3, 4'd0); issue(3'd2, 4'd4);
            exp = 16'((32'(x) * 32'(y) + 32'(w) * 32'(u)) % 65536);
            peek("R12 expression", 4'd4, exp);
            chk("R12 depth", 32'(depth), 32'd0);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule